// File: doc/BRIEF.md
# Transport Stream Packet Sync Acquisition

This block sits at the edge of a receive path for a byte-wide MPEG-style transport stream. The stream arrives with its own byte clock, a valid qualifier and an optional packet-start strobe. All of these are treated as asynchronous: they are resynchronised into the system clock domain, and one byte is captured on the chosen transition of the stream clock.

A lock engine looks for packet boundaries. The boundary marker can be the 0x47 sync byte, the external start strobe, or both together. The engine declares lock after a programmable number of correctly spaced markers. Once locked, it checks only the byte at each packet boundary and releases lock after a separate programmable number of consecutive missing markers.

While locked, the block emits each byte with a valid flag and marks the first byte of every packet. A small byte-wide register set holds the control fields, the sampling options, both thresholds and a 16-bit packet length. A read-only status register shows the lock state.

Top module: `tsync_align`

## Requirements
- R1: After reset, out_valid and out_sop are low and status bit 0 (register 6) reads 0.
- R2: Register 0 bits [1:0] select the boundary marker. 0 means no marker, so lock is never reached. 1 means the start strobe is high on the byte. 2 means the byte equals 0x47. 3 means the strobe is high and the byte equals 0x47.
- R3: While unlocked, lock is declared on the marker byte that completes N consecutive markers spaced exactly one packet length apart, where N is register 2. A value of 0 is treated as 1.
- R4: While locked, a boundary byte without a marker counts as a miss, and a boundary byte with a marker clears the miss count. Lock is lost on the boundary byte that brings consecutive misses to register 3 (0 is treated as 1). Boundary bytes below that count are still emitted with out_sop.
- R5: Packet length is register 4 (low byte) and register 5 (high byte). Values below 2 act as 2.
- R6: Register 1 bit 0 selects the capture transition: 0 captures on a rising transition of ts_clk, 1 on a falling transition.
- R7: Register 1 bit 1 set means a byte is captured only when ts_valid is high. When the bit is clear, ts_valid is ignored.
- R8: Bytes appear on out_data with out_valid only while locked, in arrival order. out_sop is high on the first byte of each packet, including the byte that completes lock.
- R9: Register 6 bit 0 reads the lock state. Writes to register 6 have no effect.
- R10: Register 0 bit 7 disables the block: no bytes are captured, lock and search state are cleared, and nothing is emitted.
- R11: The boundary byte on which lock is lost is not emitted. The search then restarts and needs the full lock count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_clk | input | 1 | Stream byte clock, asynchronous |
| ts_data | input | 8 | Stream byte |
| ts_valid | input | 1 | Stream byte qualifier |
| ts_start | input | 1 | External packet-start strobe |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| out_data | output | 8 | Aligned stream byte |
| out_valid | output | 1 | out_data holds a byte of a locked packet |
| out_sop | output | 1 | First byte of a packet |

## Verification
The hardest situation to reach is the hysteresis edge while locked. A single corrupted sync byte must keep lock and still be emitted as a packet start. A second consecutive miss must drop lock, swallow the boundary byte and force a full re-count. The bench reaches it by sending whole packets with chosen first bytes (good 0x47 or 0x00) in sequence from a locked state, then reading status between packets.

Edge selection is only visible if the two transitions see different data. The driver therefore presents the inverted byte around the transition that should not be sampled.

// File: rtl/tsync_pkg.sv
`timescale 1ns/1ps
package tsync_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;
  localparam int CNT_W  = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h47;

  typedef enum logic [1:0] {
    SM_NONE   = 2'd0,
    SM_STROBE = 2'd1,
    SM_BYTE   = 2'd2,
    SM_BOTH   = 2'd3
  } sync_mode_e;

  // packet length floor: a packet must hold at least two bytes
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    return (l < LEN_W'(2)) ? LEN_W'(2) : l;
  endfunction

  // thresholds: zero behaves like one
  function automatic logic [CNT_W-1:0] eff_thr(input logic [CNT_W-1:0] t);
    return (t == '0) ? CNT_W'(1) : t;
  endfunction

  function automatic logic is_marker(input sync_mode_e m,
                                     input logic [BYTE_W-1:0] b,
                                     input logic st);
    case (m)
      SM_STROBE: return st;
      SM_BYTE:   return (b == SYNC_BYTE);
      SM_BOTH:   return st && (b == SYNC_BYTE);
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tsync_regs.sv
`timescale 1ns/1ps
module tsync_regs
  import tsync_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              lock_state,
  output logic              blk_off,
  output sync_mode_e        mode,
  output logic              fall_sel,
  output logic              gate_valid,
  output logic [CNT_W-1:0]  lock_thr,
  output logic [CNT_W-1:0]  unlock_thr,
  output logic [LEN_W-1:0]  pkt_len
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SAMPLE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LEN_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_LEN_HI = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(6);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_off    <= 1'b0;
      mode       <= SM_BYTE;
      fall_sel   <= 1'b0;
      gate_valid <= 1'b0;
      lock_thr   <= CNT_W'(2);
      unlock_thr <= CNT_W'(2);
      pkt_len    <= LEN_W'(188);
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          blk_off <= cfg_wdata[7];
          mode    <= sync_mode_e'(cfg_wdata[1:0]);
        end
        A_SAMPLE: begin
          fall_sel   <= cfg_wdata[0];
          gate_valid <= cfg_wdata[1];
        end
        A_LOCK:   lock_thr       <= cfg_wdata;
        A_UNLOCK: unlock_thr     <= cfg_wdata;
        A_LEN_LO: pkt_len[7:0]   <= cfg_wdata;
        A_LEN_HI: pkt_len[15:8]  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      A_CTRL:   cfg_rdata = {blk_off, 5'b0, mode};
      A_SAMPLE: cfg_rdata = {6'b0, gate_valid, fall_sel};
      A_LOCK:   cfg_rdata = lock_thr;
      A_UNLOCK: cfg_rdata = unlock_thr;
      A_LEN_LO: cfg_rdata = pkt_len[7:0];
      A_LEN_HI: cfg_rdata = pkt_len[15:8];
      A_STATUS: cfg_rdata = {7'b0, lock_state};
      default:  cfg_rdata = 8'h00;
    endcase
  end

  // R9: the status address never alters the length register
  p_status_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == A_STATUS) |=> $stable(pkt_len))
    else $error("status write changed configuration");
endmodule

// File: rtl/tsync_capture.sv
`timescale 1ns/1ps
module tsync_capture
  import tsync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_off,
  input  logic              fall_sel,
  input  logic              gate_valid,
  input  logic              ts_clk,
  input  logic [BYTE_W-1:0] ts_data,
  input  logic              ts_valid,
  input  logic              ts_start,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q,
  output logic              start_q
);
  localparam int TAP = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   clk_sh;
  logic [SYNC_STAGES-1:0] vld_sh;
  logic [SYNC_STAGES-1:0] st_sh;
  logic [BYTE_W-1:0]      dat_sh [SYNC_STAGES];

  // data, valid and strobe travel through as many flops as the clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sh <= '0;
      vld_sh <= '0;
      st_sh  <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) dat_sh[i] <= '0;
    end else begin
      clk_sh    <= {clk_sh[SYNC_STAGES-1:0], ts_clk};
      vld_sh    <= {vld_sh[SYNC_STAGES-2:0], ts_valid};
      st_sh     <= {st_sh[SYNC_STAGES-2:0], ts_start};
      dat_sh[0] <= ts_data;
      for (int i = 1; i < SYNC_STAGES; i++) dat_sh[i] <= dat_sh[i-1];
    end
  end

  logic rise_seen, fall_seen, edge_hit, take;
  assign rise_seen = clk_sh[TAP] & ~clk_sh[TAP+1];
  assign fall_seen = ~clk_sh[TAP] & clk_sh[TAP+1];
  assign edge_hit  = fall_sel ? fall_seen : rise_seen;
  assign take      = edge_hit & (~gate_valid | vld_sh[TAP]) & ~blk_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_stb <= 1'b0;
      byte_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      byte_stb <= take;
      byte_q   <= dat_sh[TAP];
      start_q  <= st_sh[TAP];
    end
  end

  // R6: one transition of the chosen kind yields at most one byte
  p_one_byte_per_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb)
    else $error("two captures from one stream clock period");
endmodule

// File: rtl/tsync_lock.sv
`timescale 1ns/1ps
module tsync_lock
  import tsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_off,
  input  sync_mode_e        mode,
  input  logic [CNT_W-1:0]  lock_thr,
  input  logic [CNT_W-1:0]  unlock_thr,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_d,
  input  logic              start_d,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              locked
);
  logic             locked_q, track_q;
  logic [LEN_W-1:0] phase_q;
  logic [CNT_W-1:0] hits_q, miss_q;

  logic             locked_n, track_n;
  logic [LEN_W-1:0] phase_n;
  logic [CNT_W-1:0] hits_n, miss_n;
  logic             emit, sop_n;

  logic [LEN_W-1:0] len_e, phase_adv;
  logic [CNT_W-1:0] lthr_e, uthr_e, hits_inc, miss_inc;
  logic             marker, boundary;
  logic             lock_gain, lock_lose;

  assign len_e     = eff_len(pkt_len);
  assign lthr_e    = eff_thr(lock_thr);
  assign uthr_e    = eff_thr(unlock_thr);
  assign marker    = is_marker(mode, byte_d, start_d);
  assign boundary  = (phase_q == '0);
  assign phase_adv = (phase_q >= len_e - LEN_W'(1)) ? '0 : phase_q + LEN_W'(1);
  assign hits_inc  = track_q ? hits_q + CNT_W'(1) : CNT_W'(1);
  assign miss_inc  = miss_q + CNT_W'(1);

  always_comb begin
    locked_n  = locked_q;
    track_n   = track_q;
    phase_n   = phase_q;
    hits_n    = hits_q;
    miss_n    = miss_q;
    emit      = 1'b0;
    sop_n     = 1'b0;
    lock_gain = 1'b0;
    lock_lose = 1'b0;
    if (blk_off) begin
      locked_n = 1'b0;
      track_n  = 1'b0;
      phase_n  = '0;
      hits_n   = '0;
      miss_n   = '0;
    end else if (byte_stb) begin
      if (locked_q) begin
        if (boundary && !marker && (miss_inc >= uthr_e)) begin
          // lock lost: boundary byte swallowed, search restarts
          lock_lose = 1'b1;
          locked_n  = 1'b0;
          track_n   = 1'b0;
          phase_n   = '0;
          hits_n    = '0;
          miss_n    = '0;
        end else begin
          if (boundary) miss_n = marker ? '0 : miss_inc;
          emit    = 1'b1;
          sop_n   = boundary;
          phase_n = phase_adv;
        end
      end else if (track_q && !boundary) begin
        phase_n = phase_adv;
      end else if (marker) begin
        phase_n = LEN_W'(1);
        if (hits_inc >= lthr_e) begin
          lock_gain = 1'b1;
          locked_n  = 1'b1;
          track_n   = 1'b0;
          hits_n    = '0;
          miss_n    = '0;
          emit      = 1'b1;
          sop_n     = 1'b1;
        end else begin
          track_n = 1'b1;
          hits_n  = hits_inc;
        end
      end else begin
        track_n = 1'b0;
        hits_n  = '0;
        phase_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      track_q   <= 1'b0;
      phase_q   <= '0;
      hits_q    <= '0;
      miss_q    <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      locked_q  <= locked_n;
      track_q   <= track_n;
      phase_q   <= phase_n;
      hits_q    <= hits_n;
      miss_q    <= miss_n;
      out_valid <= emit;
      out_sop   <= sop_n;
      out_data  <= byte_d;
    end
  end

  assign locked = locked_q;

  // R3: lock only rises on a captured byte
  p_lock_on_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(byte_stb))
    else $error("lock rose without a byte");

  // R4: lock only falls on a captured byte or through disable
  p_unlock_on_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> ($past(byte_stb) || $past(blk_off)))
    else $error("lock fell without cause");

  // R8: nothing leaves the block unless it is locked
  p_out_only_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> locked_q)
    else $error("output while unlocked");

  // R2: with no marker source, lock cannot be gained
  p_no_mode_no_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && mode == SM_NONE) |=> !locked_q)
    else $error("locked with marker source off");

  // R10: disable clears lock by the next cycle
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_off |=> !locked_q)
    else $error("lock kept while disabled");

  // R11: search tracking and lock are never active together
  p_track_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_q && track_q))
    else $error("tracking while locked");
endmodule

// File: rtl/tsync_align.sv
`timescale 1ns/1ps
module tsync_align
  import tsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ts_clk,
  input  logic [7:0] ts_data,
  input  logic       ts_valid,
  input  logic       ts_start,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sop
);
  logic             blk_off, fall_sel, gate_valid, lock_state;
  sync_mode_e       mode;
  logic [CNT_W-1:0] lock_thr, unlock_thr;
  logic [LEN_W-1:0] pkt_len;
  logic             byte_stb, start_d;
  logic [BYTE_W-1:0] byte_d;

  tsync_regs #(.ADDR_W(3)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lock_state(lock_state),
    .blk_off(blk_off), .mode(mode), .fall_sel(fall_sel),
    .gate_valid(gate_valid), .lock_thr(lock_thr),
    .unlock_thr(unlock_thr), .pkt_len(pkt_len)
  );

  tsync_capture #(.SYNC_STAGES(2)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .blk_off(blk_off), .fall_sel(fall_sel), .gate_valid(gate_valid),
    .ts_clk(ts_clk), .ts_data(ts_data), .ts_valid(ts_valid),
    .ts_start(ts_start),
    .byte_stb(byte_stb), .byte_q(byte_d), .start_q(start_d)
  );

  tsync_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .blk_off(blk_off), .mode(mode),
    .lock_thr(lock_thr), .unlock_thr(unlock_thr), .pkt_len(pkt_len),
    .byte_stb(byte_stb), .byte_d(byte_d), .start_d(start_d),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
    .locked(lock_state)
  );
endmodule

// File: tb/tsync_align_test.sv
`timescale 1ns/1ps
module tsync_align_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ts_clk = 1'b0, ts_valid = 1'b0, ts_start = 1'b0;
  logic [7:0] ts_data = 8'h00;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'h00;
  wire  [7:0] cfg_rdata, out_data;
  wire        out_valid, out_sop;

  tsync_align uut (
    .clk(clk), .rst_n(rst_n), .ts_clk(ts_clk), .ts_data(ts_data),
    .ts_valid(ts_valid), .ts_start(ts_start), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_err = 0;
  bit reported = 0;
  logic [8:0] exp_q[$];

  // configuration shadow
  bit   sh_dis = 0, sh_fall = 0, sh_usev = 0;
  int   sh_mode = 2, sh_lt = 2, sh_ut = 2, sh_len = 188;
  // reference state
  bit   m_lk = 0, m_tr = 0;
  int   m_ph = 0, m_hits = 0, m_miss = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic void model_clear();
    m_lk = 0; m_tr = 0; m_ph = 0; m_hits = 0; m_miss = 0;
  endfunction

  // expected behaviour from the requirements, one captured byte at a time
  function automatic void model_byte(input logic [7:0] b, input bit st);
    bit mk;
    int plen, lt, ut;
    bit first;
    mk = (sh_mode == 1) ? st :
         (sh_mode == 2) ? (b == 8'h47) :
         (sh_mode == 3) ? (st && b == 8'h47) : 1'b0;
    plen  = (sh_len < 2) ? 2 : sh_len;
    lt    = (sh_lt == 0) ? 1 : sh_lt;
    ut    = (sh_ut == 0) ? 1 : sh_ut;
    first = (m_ph == 0);
    if (m_lk) begin
      if (first && !mk) begin
        m_miss = m_miss + 1;
        if (m_miss >= ut) begin model_clear(); return; end
      end else if (first) m_miss = 0;
      exp_q.push_back({first, b});
      m_ph = (m_ph + 1 >= plen) ? 0 : m_ph + 1;
    end else if (m_tr && !first) begin
      m_ph = (m_ph + 1 >= plen) ? 0 : m_ph + 1;
    end else if (mk) begin
      m_hits = m_tr ? m_hits + 1 : 1;
      m_ph = 1;
      if (m_hits >= lt) begin
        m_lk = 1; m_tr = 0; m_hits = 0; m_miss = 0;
        exp_q.push_back({1'b1, b});
      end else m_tr = 1;
    end else begin
      m_tr = 0; m_hits = 0; m_ph = 0;
    end
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0)
          chk(0, "R8 unexpected output", {23'd0, out_sop, out_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_sop, out_data} == e, "R8/R4 byte and sop",
              {23'd0, out_sop, out_data}, {23'd0, e});
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 200000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      3'd0: begin sh_dis = d[7]; sh_mode = d[1:0]; if (d[7]) model_clear(); end
      3'd1: begin sh_fall = d[0]; sh_usev = d[1]; end
      3'd2: sh_lt = d;
      3'd3: sh_ut = d;
      3'd4: sh_len = (sh_len & 32'hFF00) | d;
      3'd5: sh_len = (sh_len & 32'h00FF) | (d << 8);
      default: ;
    endcase
  endtask

  task automatic get_status(output logic [7:0] v);
    @(negedge clk);
    cfg_addr = 3'd6;
    #1 v = cfg_rdata;
  endtask

  task automatic expect_lock(input bit exp, input string tag);
    logic [7:0] v;
    get_status(v);
    chk(v[0] == exp, tag, v[0], exp);
  endtask

  // the byte sits on the selected transition; the other sees its inverse
  task automatic push_byte(input logic [7:0] b, input bit st, input bit v);
    if (!sh_dis && (!sh_usev || v)) model_byte(b, st);
    @(negedge clk);
    ts_data = sh_fall ? ~b : b; ts_start = st; ts_valid = v;
    repeat (3) @(negedge clk);
    ts_clk = 1;
    repeat (3) @(negedge clk);
    ts_data = sh_fall ? b : ~b;
    repeat (3) @(negedge clk);
    ts_clk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_pkt(input int len, input logic [7:0] first, input bit st,
                          input logic [7:0] seed);
    push_byte(first, st, 1);
    for (int i = 1; i < len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i);
      if (b == 8'h47) b = 8'h48;
      push_byte(b, 0, 1);
    end
  endtask

  task automatic settle(input string tag);
    repeat (16) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && out_sop == 0, "R1 outputs idle in reset",
        {out_valid, out_sop}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    expect_lock(0, "R1 status after reset");

    // sync byte mode, length 8, lock after 3, unlock after 2
    cfg_write(3'd4, 8'd8); cfg_write(3'd5, 8'd0);
    cfg_write(3'd2, 8'd3); cfg_write(3'd3, 8'd2);
    cfg_write(3'd0, 8'h02); cfg_write(3'd1, 8'h00);
    push_byte(8'h11, 0, 1); push_byte(8'h22, 0, 1); push_byte(8'h33, 0, 1);
    send_pkt(8, 8'h47, 0, 8'h10);
    send_pkt(8, 8'h47, 0, 8'h20);
    expect_lock(0, "R3 not locked after two markers");
    send_pkt(8, 8'h47, 0, 8'h30);
    expect_lock(1, "R3 locked on third marker");
    send_pkt(8, 8'h47, 0, 8'h40);
    settle("R8 all locked bytes delivered");

    // hysteresis
    send_pkt(8, 8'h00, 0, 8'h50);
    expect_lock(1, "R4 single miss keeps lock");
    send_pkt(8, 8'h47, 0, 8'h60);
    send_pkt(8, 8'h00, 0, 8'h70);
    send_pkt(8, 8'h00, 0, 8'h80);
    expect_lock(0, "R4 second consecutive miss drops lock");
    settle("R11 boundary byte on unlock not emitted");
    send_pkt(8, 8'h47, 0, 8'h90);
    send_pkt(8, 8'h47, 0, 8'hA0);
    expect_lock(0, "R11 search needs full count again");
    send_pkt(8, 8'h47, 0, 8'hB0);
    expect_lock(1, "R11 relock after full count");

    // disable, then zero lock threshold
    cfg_write(3'd0, 8'h82);
    expect_lock(0, "R10 disable clears lock");
    send_pkt(8, 8'h47, 0, 8'hC0);
    settle("R10 nothing emitted while disabled");
    expect_lock(0, "R10 still unlocked while disabled");
    cfg_write(3'd2, 8'd0);
    cfg_write(3'd0, 8'h02);
    send_pkt(8, 8'h47, 0, 8'hD0);
    expect_lock(1, "R3 zero lock count acts as one");
    settle("R3 bytes after immediate lock");

    // strobe mode
    cfg_write(3'd0, 8'h81); cfg_write(3'd2, 8'd2); cfg_write(3'd0, 8'h01);
    send_pkt(8, 8'hA5, 1, 8'h01);
    send_pkt(8, 8'hA5, 1, 8'h11);
    expect_lock(1, "R2 strobe mode locks without 0x47");
    settle("R2 strobe mode output");

    // both required
    cfg_write(3'd0, 8'h83); cfg_write(3'd0, 8'h03);
    send_pkt(8, 8'h47, 0, 8'h21);
    send_pkt(8, 8'h47, 0, 8'h31);
    send_pkt(8, 8'h47, 0, 8'h41);
    expect_lock(0, "R2 both mode ignores bare 0x47");
    send_pkt(8, 8'h47, 1, 8'h51);
    send_pkt(8, 8'h47, 1, 8'h61);
    expect_lock(1, "R2 both mode locks with strobe and 0x47");
    settle("R2 both mode output");

    // no marker source
    cfg_write(3'd0, 8'h80); cfg_write(3'd0, 8'h00);
    send_pkt(8, 8'h47, 1, 8'h71);
    send_pkt(8, 8'h47, 1, 8'h81);
    send_pkt(8, 8'h47, 1, 8'h91);
    expect_lock(0, "R2 mode 0 never locks");
    settle("R2 mode 0 no output");

    // falling edge with a 16-bit length of 260
    cfg_write(3'd0, 8'h82); cfg_write(3'd1, 8'h01);
    cfg_write(3'd4, 8'h04); cfg_write(3'd5, 8'h01);
    cfg_write(3'd0, 8'h02);
    send_pkt(260, 8'h47, 0, 8'h02);
    expect_lock(0, "R5 one marker is not enough");
    send_pkt(260, 8'h47, 0, 8'h03);
    expect_lock(1, "R5 R6 lock at length 260 on falling edge");
    send_pkt(260, 8'h47, 0, 8'h04);
    settle("R6 falling edge byte stream");

    // length below two
    cfg_write(3'd0, 8'h82); cfg_write(3'd1, 8'h00);
    cfg_write(3'd4, 8'd1); cfg_write(3'd5, 8'd0);
    cfg_write(3'd0, 8'h02);
    push_byte(8'h47, 0, 1); push_byte(8'h33, 0, 1);
    push_byte(8'h47, 0, 1); push_byte(8'h34, 0, 1);
    expect_lock(1, "R5 length 1 acts as 2");
    settle("R5 short packet output");

    // valid gating
    cfg_write(3'd0, 8'h82); cfg_write(3'd1, 8'h02);
    cfg_write(3'd4, 8'd8); cfg_write(3'd0, 8'h02);
    for (int p = 0; p < 3; p++) begin
      push_byte(8'h47, 0, 1);
      for (int i = 1; i < 8; i++) begin
        push_byte(8'(8'h60 + i), 0, 1);
        if (i == 2) push_byte(8'h47, 0, 0);
      end
    end
    expect_lock(1, "R7 invalid bytes skipped when gated");
    settle("R7 gated stream output");
    cfg_write(3'd1, 8'h00);
    push_byte(8'h47, 0, 1);
    push_byte(8'h61, 0, 1);
    push_byte(8'hEE, 0, 0);
    for (int i = 2; i < 7; i++) push_byte(8'(8'h60 + i), 0, 1);
    settle("R7 valid ignored, low-valid byte emitted");
    expect_lock(1, "R7 still locked");

    // status register is read-only
    cfg_write(3'd6, 8'h00);
    expect_lock(1, "R9 status write ignored while locked");
    cfg_write(3'd0, 8'h82);
    cfg_write(3'd6, 8'hFF);
    expect_lock(0, "R9 status write ignored while unlocked");
    cfg_addr = 3'd4;
    #1 chk(cfg_rdata == 8'd8, "R9 length unchanged by status write", cfg_rdata, 8);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule